// File: doc/BRIEF.md
# Texel Colour Mode Converter

This block turns one fetched texel word into a 24-bit RGB colour. It sits after texture fetch in a tiled rasteriser. Each pixel arrives with a texel word, a 3-bit display mode and a 2-bit ramp index, all taken from the primitive being drawn. The block can show the texel directly as monochrome or as one of two packed full-colour layouts. In ramp mode it instead uses the texel's brightness as a weight to blend between the two endpoint colours of one of four stored ramps. Ramp mode is what produces thermal-style false-colour views.

Ramp endpoints are written through a small register port into a staging copy. The copy the datapath uses is only replaced when a start-of-primitive strobe arrives, so a primitive never sees a half-loaded ramp. The same port reads back the live endpoints and a sticky flag that records any use of an undefined mode. Pixels pass through a two-stage pipeline with a valid/ready handshake on both sides.

Top module: `texel_colour_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. Every ramp reads back endpoint 0 = 0x000000 and endpoint 1 = 0xFFFFFF. The status word reads 0.
- R2: Mode 4 (monochrome) copies texel bits [7:0] to red, green and blue. Texel bits above bit 7 have no effect.
- R3: Mode 6 (3-3-2) takes red = texel[7:5], green = texel[4:2] and blue = texel[1:0]. Each 3-bit field abc widens to abcabcab, and each 2-bit field ab widens to abababab.
- R4: Mode 7 (4-4-4) takes red = texel[11:8], green = texel[7:4] and blue = texel[3:0]. Each nibble widens to the nibble repeated twice.
- R5: Mode 0 (ramp) uses L = texel[7:0] and the weight w = L + L[7]. Each output channel is (c0·(256−w) + c1·w + 128) >> 8, saturated to 255. As a result, L = 0 gives exactly endpoint 0 and L = 255 gives exactly endpoint 1.
- R6: The pixel's ramp index picks ramp 0 to 3. The other ramps have no effect on that pixel.
- R7: Register address 2·ramp + e (e = 0 or 1) writes endpoint e of that ramp into a staging copy. Reads of addresses 0–7 return the live copy. The live copy takes the staged value at the clock edge where `prim_start` is 1, and not before.
- R8: Mode codes 1, 2, 3 and 5 produce 0x000000 and set a sticky error flag, read at address 8 in bit 0. A write to address 8 clears the flag. A new error in the same cycle as that write takes priority over the clear.
- R9: A pixel accepted at clock edge k appears on `out_valid`/`out_rgb` after edge k+1. It does not appear after edge k alone.
- R10: While `out_valid` is 1 and `out_ready` is 0, the output holds its value and `in_ready` is 0. Pixels queued behind it then come out in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address (0–7 ramp endpoints, 8 status) |
| cfg_wdata | input | 24 | Write data, RGB888 |
| cfg_rdata | output | 24 | Read data for `cfg_addr` |
| prim_start | input | 1 | Start-of-primitive strobe; copies staged ramps to the live copy |
| in_valid | input | 1 | Pixel input valid |
| in_ready | output | 1 | Pixel input accepted when high |
| in_texel | input | 12 | Raw texel word |
| in_mode | input | 3 | Display mode code |
| in_ramp | input | 2 | Ramp index |
| out_valid | output | 1 | Output colour valid |
| out_ready | input | 1 | Downstream ready |
| out_rgb | output | 24 | Colour, red in [23:16] |

## Verification
The likely internal faults are a stale live ramp, a wrong staging commit, and a stage register that drops or duplicates a pixel under backpressure. A stale live ramp or a wrong commit shows up at once in readback of addresses 0–7. It also shows up on the colour of the first ramp-mode pixel two cycles after it is accepted. A lost or repeated pixel shows up as a wrong colour, or a missing `out_valid`, at the first edge after `out_ready` returns. A flag stuck high or low shows up on the next status read.

// File: rtl/texcol_pkg.sv
package texcol_pkg;

    localparam int CH_W  = 8;
    localparam int RGB_W = 3 * CH_W;

    typedef logic [CH_W-1:0] chan_t;

    typedef struct packed {
        chan_t r;
        chan_t g;
        chan_t b;
    } rgb_t;

    typedef enum logic [2:0] {
        TM_RAMP = 3'd0,
        TM_MONO = 3'd4,
        TM_P332 = 3'd6,
        TM_P444 = 3'd7
    } tex_mode_e;

    localparam rgb_t RGB_BLACK = '{r: 8'h00, g: 8'h00, b: 8'h00};
    localparam rgb_t RGB_WHITE = '{r: 8'hFF, g: 8'hFF, b: 8'hFF};

    // pipeline stage 1 contents
    typedef struct packed {
        logic  valid;
        logic  use_ramp;
        rgb_t  direct;
        chan_t lum;
        rgb_t  end0;
        rgb_t  end1;
    } stage1_t;

    function automatic chan_t widen2(input logic [1:0] v);
        return {v, v, v, v};
    endfunction

    function automatic chan_t widen3(input logic [2:0] v);
        return {v, v, v[2:1]};
    endfunction

    function automatic chan_t widen4(input logic [3:0] v);
        return {v, v};
    endfunction

    // weighted blend of two channel values; weight reaches 256 at lum=255
    function automatic chan_t blend_chan(input chan_t c0, input chan_t c1, input chan_t lum);
        logic [8:0]  w;
        logic [8:0]  wn;
        logic [17:0] acc;
        w   = {1'b0, lum} + {8'd0, lum[7]};
        wn  = 9'd256 - w;
        acc = ({10'd0, c0} * {9'd0, wn}) + ({10'd0, c1} * {9'd0, w}) + 18'd128;
        if (acc[17:16] != 2'b00) begin
            return 8'hFF;
        end
        return acc[15:8];
    endfunction

endpackage

// File: rtl/texcol_decode.sv
module texcol_decode
    import texcol_pkg::*;
#(
    parameter int TEXEL_W = 12
) (
    input  logic [TEXEL_W-1:0] texel,
    input  logic [2:0]         mode,
    output rgb_t               direct,
    output chan_t              lum,
    output logic               use_ramp,
    output logic               bad_mode
);

    always_comb begin
        direct   = RGB_BLACK;
        lum      = texel[7:0];
        use_ramp = 1'b0;
        bad_mode = 1'b0;
        case (tex_mode_e'(mode))
            TM_RAMP: begin
                use_ramp = 1'b1;
            end
            TM_MONO: begin
                direct = '{r: texel[7:0], g: texel[7:0], b: texel[7:0]};
            end
            TM_P332: begin
                direct = '{r: widen3(texel[7:5]),
                           g: widen3(texel[4:2]),
                           b: widen2(texel[1:0])};
            end
            TM_P444: begin
                direct = '{r: widen4(texel[11:8]),
                           g: widen4(texel[7:4]),
                           b: widen4(texel[3:0])};
            end
            default: begin
                bad_mode = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/texcol_ramp_bank.sv
module texcol_ramp_bank
    import texcol_pkg::*;
#(
    parameter int NUM_RAMPS = 4,
    parameter int ADDR_W    = 4,
    localparam int ENTRIES  = 2 * NUM_RAMPS,
    localparam int SEL_W    = (NUM_RAMPS > 1) ? $clog2(NUM_RAMPS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  rgb_t              wr_data,
    input  logic              commit,
    input  logic [SEL_W-1:0]  sel,
    output rgb_t              sel_end0,
    output rgb_t              sel_end1,
    input  logic [ADDR_W-1:0] rd_addr,
    output rgb_t              rd_data
);

    rgb_t stage_q [ENTRIES];
    rgb_t live_q  [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < ENTRIES; k++) begin
                stage_q[k] <= (k % 2 == 1) ? RGB_WHITE : RGB_BLACK;
                live_q[k]  <= (k % 2 == 1) ? RGB_WHITE : RGB_BLACK;
            end
        end else begin
            for (int k = 0; k < ENTRIES; k++) begin
                if (wr_en && (wr_addr == ADDR_W'(k))) begin
                    stage_q[k] <= wr_data;
                end
                if (commit) begin
                    live_q[k] <= stage_q[k];
                end
            end
        end
    end

    always_comb begin
        sel_end0 = RGB_BLACK;
        sel_end1 = RGB_BLACK;
        for (int r = 0; r < NUM_RAMPS; r++) begin
            if (sel == SEL_W'(r)) begin
                sel_end0 = live_q[2*r];
                sel_end1 = live_q[2*r+1];
            end
        end
    end

    always_comb begin
        rd_data = RGB_BLACK;
        for (int k = 0; k < ENTRIES; k++) begin
            if (rd_addr == ADDR_W'(k)) begin
                rd_data = live_q[k];
            end
        end
    end

endmodule

// File: rtl/texcol_blend.sv
module texcol_blend
    import texcol_pkg::*;
(
    input  logic  use_ramp,
    input  rgb_t  direct,
    input  chan_t lum,
    input  rgb_t  end0,
    input  rgb_t  end1,
    output rgb_t  colour
);

    logic [2:0][CH_W-1:0] e0_v;
    logic [2:0][CH_W-1:0] e1_v;
    logic [2:0][CH_W-1:0] mix_v;

    assign e0_v = end0;
    assign e1_v = end1;

    for (genvar c = 0; c < 3; c++) begin : g_chan
        assign mix_v[c] = blend_chan(e0_v[c], e1_v[c], lum);
    end

    assign colour = use_ramp ? rgb_t'(mix_v) : direct;

endmodule

// File: rtl/texel_colour_unit.sv
module texel_colour_unit
    import texcol_pkg::*;
#(
    parameter int TEXEL_W   = 12,
    parameter int NUM_RAMPS = 4,
    localparam int RAMP_W   = (NUM_RAMPS > 1) ? $clog2(NUM_RAMPS) : 1,
    localparam int CFG_AW   = $clog2(2 * NUM_RAMPS + 1),
    localparam int STATUS_ADDR = 2 * NUM_RAMPS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [23:0]        cfg_wdata,
    output logic [23:0]        cfg_rdata,
    input  logic               prim_start,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [TEXEL_W-1:0] in_texel,
    input  logic [2:0]         in_mode,
    input  logic [RAMP_W-1:0]  in_ramp,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [23:0]        out_rgb
);

    stage1_t s1_q;
    logic    s2_valid_q;
    rgb_t    s2_rgb_q;
    logic    err_q;
    logic    advance;

    rgb_t  dec_direct;
    chan_t dec_lum;
    logic  dec_use_ramp;
    logic  dec_bad;
    rgb_t  sel_end0;
    rgb_t  sel_end1;
    rgb_t  live_rd;
    rgb_t  blend_out;
    logic  status_wr;

    assign advance   = !s2_valid_q || out_ready;
    assign in_ready  = advance;
    assign status_wr = cfg_we && (cfg_addr == CFG_AW'(STATUS_ADDR));

    texcol_decode #(.TEXEL_W(TEXEL_W)) u_decode (
        .texel    (in_texel),
        .mode     (in_mode),
        .direct   (dec_direct),
        .lum      (dec_lum),
        .use_ramp (dec_use_ramp),
        .bad_mode (dec_bad)
    );

    texcol_ramp_bank #(.NUM_RAMPS(NUM_RAMPS), .ADDR_W(CFG_AW)) u_ramps (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_addr),
        .wr_data  (rgb_t'(cfg_wdata)),
        .commit   (prim_start),
        .sel      (in_ramp),
        .sel_end0 (sel_end0),
        .sel_end1 (sel_end1),
        .rd_addr  (cfg_addr),
        .rd_data  (live_rd)
    );

    texcol_blend u_blend (
        .use_ramp (s1_q.use_ramp),
        .direct   (s1_q.direct),
        .lum      (s1_q.lum),
        .end0     (s1_q.end0),
        .end1     (s1_q.end1),
        .colour   (blend_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q       <= '0;
            s2_valid_q <= 1'b0;
            s2_rgb_q   <= RGB_BLACK;
        end else if (advance) begin
            s1_q.valid    <= in_valid;
            s1_q.use_ramp <= dec_use_ramp;
            s1_q.direct   <= dec_direct;
            s1_q.lum      <= dec_lum;
            s1_q.end0     <= sel_end0;
            s1_q.end1     <= sel_end1;
            s2_valid_q    <= s1_q.valid;
            s2_rgb_q      <= blend_out;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (in_valid && advance && dec_bad) begin
            err_q <= 1'b1;
        end else if (status_wr) begin
            err_q <= 1'b0;
        end
    end

    always_comb begin
        if (cfg_addr == CFG_AW'(STATUS_ADDR)) begin
            cfg_rdata = {23'd0, err_q};
        end else begin
            cfg_rdata = live_rd;
        end
    end

    assign out_valid = s2_valid_q;
    assign out_rgb   = s2_rgb_q;

endmodule

// File: rtl/texcol_chk.sv
module texcol_chk #(
    parameter int CFG_AW      = 4,
    parameter int STATUS_ADDR = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [2:0]        in_mode,
    input logic              out_valid,
    input logic              out_ready,
    input logic [23:0]       out_rgb,
    input logic              cfg_we,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic              err_q
);

    logic mode_undef;
    logic clr_wr;

    assign mode_undef = !(in_mode inside {3'd0, 3'd4, 3'd6, 3'd7});
    assign clr_wr     = cfg_we && (cfg_addr == CFG_AW'(STATUS_ADDR));

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_rgb));

    // R10
    stall_ready_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);

    // R9
    two_stage_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> ##1 out_valid);

    // R8
    err_raise_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && mode_undef |=> err_q);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_q && !clr_wr |=> err_q);

endmodule

bind texel_colour_unit texcol_chk #(.CFG_AW(CFG_AW), .STATUS_ADDR(STATUS_ADDR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_mode   (in_mode),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_rgb   (out_rgb),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .err_q     (err_q)
);

// File: tb/texel_colour_unit_bench.sv
module texel_colour_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [23:0] cfg_wdata = '0;
    logic [23:0] cfg_rdata;
    logic        prim_start = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [11:0] in_texel = '0;
    logic [2:0]  in_mode = '0;
    logic [1:0]  in_ramp = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [23:0] out_rgb;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    texel_colour_unit u_texel_colour_unit (.*);

    task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%06h expected=%06h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mix(input logic [7:0] a, input logic [7:0] b, input logic [7:0] l);
        int w, v;
        w = int'(l) + (l >= 8'd128 ? 1 : 0);
        v = (int'(a) * (256 - w) + int'(b) * w + 128) / 256;
        if (v > 255) v = 255;
        return v[7:0];
    endfunction

    function automatic logic [23:0] ramp_exp(input logic [23:0] c0, input logic [23:0] c1, input logic [7:0] l);
        return {mix(c0[23:16], c1[23:16], l), mix(c0[15:8], c1[15:8], l), mix(c0[7:0], c1[7:0], l)};
    endfunction

    task automatic cfg_write(input logic [3:0] a, input logic [23:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_check(input logic [3:0] a, input logic [23:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(cfg_rdata == exp, tag, cfg_rdata, exp);
    endtask

    task automatic commit_prim();
        @(negedge clk);
        prim_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        prim_start = 1'b0;
    endtask

    task automatic pixel(input logic [11:0] t, input logic [2:0] m, input logic [1:0] r,
                         input logic [23:0] exp, input string tag);
        @(negedge clk);
        out_ready = 1'b1;
        in_valid = 1'b1; in_texel = t; in_mode = m; in_ramp = r;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(!out_valid, "R9 no output after one edge", {23'd0, out_valid}, 24'd0);
        @(posedge clk);
        @(negedge clk);
        check(out_valid && out_rgb == exp, tag, out_rgb, exp);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(!out_valid, "R1 out_valid low", {23'd0, out_valid}, 24'd0);
        check(in_ready, "R1 in_ready high", {23'd0, in_ready}, 24'd1);
        for (int k = 0; k < 8; k++) begin
            cfg_check(4'(k), (k % 2 == 1) ? 24'hFFFFFF : 24'h000000, "R1 ramp reset value");
        end
        cfg_check(4'd8, 24'd0, "R1 status clear");
    endtask

    task automatic test_direct();
        pixel(12'h05A, 3'd4, 2'd0, 24'h5A5A5A, "R2 mono");
        pixel(12'hF00, 3'd4, 2'd0, 24'h000000, "R2 mono upper bits ignored");
        pixel(12'h0B6, 3'd6, 2'd0, 24'hB6B6AA, "R3 332 widen");
        pixel(12'h01F, 3'd6, 2'd0, 24'h00FFFF, "R3 332 extremes");
        pixel(12'h3C9, 3'd7, 2'd0, 24'h33CC99, "R4 444 widen");
    endtask

    task automatic test_ramp_default();
        pixel(12'h000, 3'd0, 2'd0, 24'h000000, "R5 L=0 gives endpoint 0");
        pixel(12'h0FF, 3'd0, 2'd0, 24'hFFFFFF, "R5 L=255 gives endpoint 1");
        pixel(12'h080, 3'd0, 2'd1, ramp_exp(24'h0, 24'hFFFFFF, 8'h80), "R5 L=128 midpoint");
    endtask

    task automatic test_ramp_staging();
        cfg_write(4'd4, 24'h102030);
        cfg_write(4'd5, 24'hF0E0D0);
        cfg_check(4'd4, 24'h000000, "R7 staged write not live");
        pixel(12'h0FF, 3'd0, 2'd2, 24'hFFFFFF, "R7 pixel before commit uses old ramp");
        commit_prim();
        cfg_check(4'd4, 24'h102030, "R7 live after commit");
        cfg_check(4'd5, 24'hF0E0D0, "R7 live endpoint 1 after commit");
        pixel(12'h000, 3'd0, 2'd2, 24'h102030, "R5 loaded ramp L=0");
        pixel(12'h0FF, 3'd0, 2'd2, 24'hF0E0D0, "R5 loaded ramp L=255");
        pixel(12'h040, 3'd0, 2'd2, ramp_exp(24'h102030, 24'hF0E0D0, 8'h40), "R5 loaded ramp L=64");
        pixel(12'h0FF, 3'd0, 2'd0, 24'hFFFFFF, "R6 ramp 0 unaffected");
        pixel(12'h000, 3'd0, 2'd3, 24'h000000, "R6 ramp 3 unaffected");
    endtask

    task automatic test_error();
        pixel(12'h0FF, 3'd5, 2'd0, 24'h000000, "R8 undefined mode is black");
        cfg_check(4'd8, 24'd1, "R8 flag set");
        pixel(12'h011, 3'd4, 2'd0, 24'h111111, "R8 valid mode after error");
        cfg_check(4'd8, 24'd1, "R8 flag sticky");
        cfg_write(4'd8, 24'd0);
        cfg_check(4'd8, 24'd0, "R8 flag cleared");
        pixel(12'h0AA, 3'd2, 2'd0, 24'h000000, "R8 mode 2 black");
        cfg_check(4'd8, 24'd1, "R8 flag set by mode 2");
        cfg_write(4'd8, 24'd0);
    endtask

    task automatic test_backpressure();
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_texel = 12'h012; in_mode = 3'd4; in_ramp = 2'd0;
        @(posedge clk);
        @(negedge clk);
        in_texel = 12'h034;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && out_rgb == 24'h121212, "R9 first pixel out", out_rgb, 24'h121212);
        check(!in_ready, "R10 in_ready low while stalled", {23'd0, in_ready}, 24'd0);
        @(posedge clk);
        @(negedge clk);
        check(out_valid && out_rgb == 24'h121212, "R10 output held", out_rgb, 24'h121212);
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(out_valid && out_rgb == 24'h343434, "R10 second pixel in order", out_rgb, 24'h343434);
        @(posedge clk);
        @(negedge clk);
        check(!out_valid, "R10 pipeline drained", {23'd0, out_valid}, 24'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%06h expected=%06h", 24'd0, 24'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_direct();
        test_ramp_default();
        test_ramp_staging();
        test_error();
        test_backpressure();
        finish_run();
    end

endmodule